// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the status word that a flash device hands back on reads while an internal program or erase operation is running, suspended or has failed. It also drives the ready indication. The engine that times the operation reports its current phase on `eng_state`. The command decoder supplies bit 7 of the last program datum, and the sector bookkeeping supplies a mask of sectors chosen for erase. For every read, the surrounding logic gives the sector index of the read address and pulses a one-cycle read strobe.

The block answers that strobe one cycle later with a registered status word and a flag `stat_sel`. The flag tells the read path whether to return this status word or the array contents. The two toggle flags flip once per read access, not once per clock, so a host that polls twice in a row can see whether work is still in progress. The other status bits depend on three things together: the operation phase, whether the operation was a program or an erase, and whether the read address falls inside a sector chosen for erase.

Top module: `flst_status_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `stat_word` is 0, `stat_sel` is 0 and `ready` is 1. Both toggle flags restart from 0, so the first toggling read after reset returns 1 in that toggle bit.
- R2: A read strobed in state PROG (1) or SPROG (5) returns `stat_sel`=1, with bit 7 equal to the inverse of `prog_d7` and bits 5 and 3 equal to 0.
- R3: Bit 6 inverts on every strobe in PROG, EWIN (2), ERASE (3), SPROG or FAIL (6), whatever the address. It holds on strobes in IDLE (0) and SUSP (4). Without a strobe, `stat_word` and `stat_sel` do not change.
- R4: Bit 2 inverts on a strobe in EWIN, ERASE or SUSP, or in FAIL after an erase, only when `sel_mask[rd_sector]` is 1. In every other case it holds.
- R5: A read in EWIN returns bit 7 = 0 and bit 3 = 0. A read in ERASE returns bit 7 = 0 and bit 3 = 1.
- R6: In SUSP, a read of a selected sector returns `stat_sel`=1, bit 7 = 1 and bit 6 unchanged. A read of an unselected sector returns `stat_sel`=0 and a word of 0.
- R7: In FAIL, bit 5 reads 1. If the last active operation was an erase, bit 7 = 0 and bit 3 = 1. If it was a program, bit 7 is the inverse of `prog_d7` and bit 3 = 0.
- R8: `ready` is 0 in the cycle after the state is PROG, EWIN, ERASE, SPROG or FAIL, and 1 in the cycle after IDLE or SUSP.
- R9: Bits 15..8, 4, 1 and 0 of `stat_word` are always 0.
- R10: A read in IDLE returns `stat_sel`=0 and a word of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_state | input | 3 | Engine phase: 0 IDLE, 1 PROG, 2 EWIN, 3 ERASE, 4 SUSP, 5 SPROG, 6 FAIL |
| prog_d7 | input | 1 | Bit 7 of the last program datum |
| sel_mask | input | NSECT | Sectors chosen for erase |
| rd_sector | input | SECT_W | Sector index of the read address |
| rd_strobe | input | 1 | One-cycle read access pulse |
| stat_word | output | WORD_W | Registered status word |
| stat_sel | output | 1 | Status word replaces array data for this read |
| ready | output | 1 | High when no operation keeps the device busy |

## Verification
Two things can land on the same read strobe. First, both toggle flags can flip on one access: an erase read of a selected sector inverts bit 6 and bit 2 together. Second, the engine can change phase in the very cycle of a strobe. The bench provokes the second case by changing `eng_state` from IDLE to ERASE on the strobe edge itself. It judges that the returned word follows the new phase (bit 3 = 1, bit 7 = 0) and that both toggle bits advance exactly once against its own model of the toggle flags.

// File: rtl/flst_pkg.sv
package flst_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE  = 3'd0,
    ENG_PROG  = 3'd1,
    ENG_EWIN  = 3'd2,
    ENG_ERASE = 3'd3,
    ENG_SUSP  = 3'd4,
    ENG_SPROG = 3'd5,
    ENG_FAIL  = 3'd6
  } eng_state_t;

  localparam int B_POLL  = 7;
  localparam int B_TOG   = 6;
  localparam int B_LIMIT = 5;
  localparam int B_TIMER = 3;
  localparam int B_SECT  = 2;

  typedef struct packed {
    logic show;
    logic poll;
    logic run6;
    logic run2;
    logic limit;
    logic timer;
    logic busy;
  } stat_ctl_t;
endpackage

// File: rtl/flst_opmem.sv
module flst_opmem
  import flst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] eng_state,
  output logic       last_erase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      last_erase <= 1'b0;
    end else begin
      case (eng_state_t'(eng_state))
        ENG_PROG, ENG_SPROG:           last_erase <= 1'b0;
        ENG_EWIN, ENG_ERASE, ENG_SUSP: last_erase <= 1'b1;
        default:                       last_erase <= last_erase;
      endcase
    end
  end
endmodule

// File: rtl/flst_decode.sv
module flst_decode
  import flst_pkg::*;
#(
  parameter int NSECT  = 19,
  parameter int SECT_W = $clog2(NSECT)
) (
  input  logic [2:0]        eng_state,
  input  logic              prog_d7,
  input  logic              last_erase,
  input  logic [NSECT-1:0]  sel_mask,
  input  logic [SECT_W-1:0] rd_sector,
  output stat_ctl_t         ctl
);
  localparam logic [SECT_W:0] SECT_LIM = (SECT_W+1)'(NSECT);

  logic in_sel;

  always_comb begin
    in_sel = 1'b0;
    if ({1'b0, rd_sector} < SECT_LIM) in_sel = sel_mask[rd_sector];
  end

  always_comb begin
    ctl = '0;
    case (eng_state_t'(eng_state))
      ENG_PROG, ENG_SPROG: begin
        ctl.show = 1'b1;
        ctl.poll = ~prog_d7;
        ctl.run6 = 1'b1;
        ctl.busy = 1'b1;
      end
      ENG_EWIN, ENG_ERASE: begin
        ctl.show  = 1'b1;
        ctl.run6  = 1'b1;
        ctl.run2  = in_sel;
        ctl.timer = (eng_state_t'(eng_state) == ENG_ERASE);
        ctl.busy  = 1'b1;
      end
      ENG_SUSP: begin
        ctl.show = in_sel;
        ctl.poll = 1'b1;
        ctl.run2 = in_sel;
      end
      ENG_FAIL: begin
        ctl.show  = 1'b1;
        ctl.limit = 1'b1;
        ctl.run6  = 1'b1;
        ctl.busy  = 1'b1;
        ctl.poll  = last_erase ? 1'b0 : ~prog_d7;
        ctl.timer = last_erase;
        ctl.run2  = last_erase & in_sel;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/flst_toggle.sv
module flst_toggle #(
  parameter int NTOG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [NTOG-1:0] run,
  output logic [NTOG-1:0] nxt
);
  logic [NTOG-1:0] q;

  for (genvar i = 0; i < NTOG; i++) begin : g_cell
    assign nxt[i] = (strobe && run[i]) ? ~q[i] : q[i];
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/flst_status_gen.sv
module flst_status_gen
  import flst_pkg::*;
#(
  parameter int NSECT  = 19,
  parameter int SECT_W = $clog2(NSECT),
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        eng_state,
  input  logic              prog_d7,
  input  logic [NSECT-1:0]  sel_mask,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] stat_word,
  output logic              stat_sel,
  output logic              ready
);
  localparam int T6 = 0;
  localparam int T2 = 1;

  stat_ctl_t         ctl;
  logic              last_erase;
  logic [1:0]        tog_run;
  logic [1:0]        tog_nxt;
  logic [WORD_W-1:0] word_d;

  flst_opmem u_opmem (
    .clk        (clk),
    .rst        (rst),
    .eng_state  (eng_state),
    .last_erase (last_erase)
  );

  flst_decode #(.NSECT(NSECT), .SECT_W(SECT_W)) u_dec (
    .eng_state  (eng_state),
    .prog_d7    (prog_d7),
    .last_erase (last_erase),
    .sel_mask   (sel_mask),
    .rd_sector  (rd_sector),
    .ctl        (ctl)
  );

  assign tog_run[T6] = ctl.run6;
  assign tog_run[T2] = ctl.run2;

  flst_toggle #(.NTOG(2)) u_tog (
    .clk    (clk),
    .rst    (rst),
    .strobe (rd_strobe),
    .run    (tog_run),
    .nxt    (tog_nxt)
  );

  always_comb begin
    word_d = '0;
    if (ctl.show) begin
      word_d[B_POLL]  = ctl.poll;
      word_d[B_TOG]   = tog_nxt[T6];
      word_d[B_LIMIT] = ctl.limit;
      word_d[B_TIMER] = ctl.timer;
      word_d[B_SECT]  = tog_nxt[T2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_word <= '0;
      stat_sel  <= 1'b0;
      ready     <= 1'b1;
    end else begin
      ready <= ~ctl.busy;
      if (rd_strobe) begin
        stat_word <= word_d;
        stat_sel  <= ctl.show;
      end
    end
  end
endmodule

// File: rtl/flst_status_chk.sv
module flst_status_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        eng_state,
  input logic              prog_d7,
  input logic              rd_strobe,
  input logic [WORD_W-1:0] stat_word,
  input logic              stat_sel,
  input logic              ready
);
  localparam logic [WORD_W-1:0] USED = WORD_W'(16'h00EC);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R9
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_word & ~USED) == '0);

  // R10
  gated_word_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_sel |-> stat_word == '0);

  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rd_strobe) |-> ($stable(stat_word) && $stable(stat_sel)));

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rd_strobe) && $past(eng_state) == 3'd1) |-> (stat_word[7] == !$past(prog_d7)));

  // R5
  erase_timer_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rd_strobe) && $past(eng_state) == 3'd3) |-> (stat_word[3] && !stat_word[7]));

  // R7
  fail_limit_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rd_strobe) && $past(eng_state) == 3'd6) |-> stat_word[5]);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(eng_state) == 3'd1 || $past(eng_state) == 3'd2 || $past(eng_state) == 3'd3 ||
     $past(eng_state) == 3'd5 || $past(eng_state) == 3'd6) |-> !ready);
endmodule

bind flst_status_gen flst_status_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .eng_state (eng_state),
  .prog_d7   (prog_d7),
  .rd_strobe (rd_strobe),
  .stat_word (stat_word),
  .stat_sel  (stat_sel),
  .ready     (ready)
);

// File: tb/sim_flst_status_gen.sv
module sim_flst_status_gen;
  localparam int NSECT  = 19;
  localparam int SW     = $clog2(NSECT);
  localparam int WORD_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        eng_state = 3'd0;
  logic              prog_d7 = 1'b0;
  logic [NSECT-1:0]  sel_mask = '0;
  logic [SW-1:0]     rd_sector = '0;
  logic              rd_strobe = 1'b0;
  logic [WORD_W-1:0] stat_word;
  logic              stat_sel;
  logic              ready;

  int  checks = 0;
  int  failures = 0;
  bit  e6 = 1'b0;
  bit  e2 = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  flst_status_gen #(.NSECT(NSECT), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst(rst), .eng_state(eng_state), .prog_d7(prog_d7),
    .sel_mask(sel_mask), .rd_sector(rd_sector), .rd_strobe(rd_strobe),
    .stat_word(stat_word), .stat_sel(stat_sel), .ready(ready)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go(input logic [2:0] s, input bit exp_rdy, input string req);
    eng_state = s;
    @(negedge clk);
    chk({31'd0, ready}, {31'd0, exp_rdy}, req);
  endtask

  task automatic rd(input int sec, input bit t6, input bit t2, input bit sh,
                    input bit q7, input bit q5, input bit q3, input string req);
    logic [15:0] exp;
    rd_sector = sec[SW-1:0];
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    if (t6) e6 = ~e6;
    if (t2) e2 = ~e2;
    exp = sh ? {8'h00, q7, e6, q5, 1'b0, q3, e2, 2'b00} : 16'h0000;
    chk({16'd0, stat_word}, {16'd0, exp}, req);
    chk({31'd0, stat_sel}, {31'd0, sh}, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({15'd0, stat_word, stat_sel}, 32'd0, "R1 during reset");
    chk({31'd0, ready}, 32'd1, "R1 ready in reset");
    rst = 1'b0;
    @(negedge clk);
    chk({15'd0, stat_word, stat_sel}, 32'd0, "R1 after reset");
  endtask

  task automatic t_idle;
    go(3'd0, 1'b1, "R8 idle ready");
    rd(4, 0, 0, 0, 0, 0, 0, "R10 idle read");
  endtask

  task automatic t_program;
    logic [15:0] held;
    prog_d7 = 1'b1;
    go(3'd1, 1'b0, "R8 program busy");
    rd(0, 1, 0, 1, 0, 0, 0, "R2 complement of 1");
    rd(7, 1, 0, 1, 0, 0, 0, "R3 toggle any address");
    prog_d7 = 1'b0;
    rd(2, 1, 0, 1, 1, 0, 0, "R2 complement of 0");
    held = stat_word;
    repeat (4) @(negedge clk);
    chk({16'd0, stat_word}, {16'd0, held}, "R3 no strobe holds");
  endtask

  task automatic t_erase;
    sel_mask = '0;
    sel_mask[3] = 1'b1;
    sel_mask[10] = 1'b1;
    go(3'd2, 1'b0, "R8 window busy");
    rd(3, 1, 1, 1, 0, 0, 0, "R4 window selected");
    rd(5, 1, 0, 1, 0, 0, 0, "R4 window unselected");
    go(3'd3, 1'b0, "R8 erase busy");
    rd(10, 1, 1, 1, 0, 0, 1, "R5 erasing selected");
  endtask

  task automatic t_suspend;
    go(3'd4, 1'b1, "R8 suspend ready");
    rd(3, 0, 1, 1, 1, 0, 0, "R6 suspended sector");
    rd(5, 0, 0, 0, 0, 0, 0, "R6 other sector array");
    prog_d7 = 1'b1;
    go(3'd5, 1'b0, "R8 suspend program busy");
    rd(5, 1, 0, 1, 0, 0, 0, "R2 suspend program");
  endtask

  task automatic t_fail;
    go(3'd3, 1'b0, "R8 erase again");
    go(3'd6, 1'b0, "R8 fail busy");
    rd(10, 1, 1, 1, 0, 1, 1, "R7 erase failure");
    rd(9, 1, 0, 1, 0, 1, 1, "R4 failure unselected");
    go(3'd0, 1'b1, "R8 back to idle");
    rd(3, 0, 0, 0, 0, 0, 0, "R10 idle after fail");
    prog_d7 = 1'b0;
    go(3'd1, 1'b0, "R8 program busy");
    go(3'd6, 1'b0, "R8 fail busy");
    rd(3, 1, 0, 1, 1, 1, 0, "R7 program failure");
  endtask

  task automatic t_same_cycle;
    go(3'd0, 1'b1, "R8 idle");
    eng_state = 3'd3;
    rd(10, 1, 1, 1, 0, 0, 1, "R4 state change on strobe");
    chk({31'd0, ready}, 32'd0, "R8 busy at same cycle");
  endtask

  task automatic t_rereset;
    rst = 1'b1;
    @(negedge clk);
    chk({15'd0, stat_word, stat_sel}, 32'd0, "R1 reapplied");
    rst = 1'b0;
    e6 = 1'b0;
    e2 = 1'b0;
    rd(10, 1, 1, 1, 0, 0, 1, "R1 toggles restart");
    chk({16'd0, stat_word & 16'hFF13}, 32'd0, "R9 spare bits");
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_suspend();
    t_fail();
    t_same_cycle();
    t_rereset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule